// File: doc/BRIEF.md
# Paged Effective Address Generator

This unit resolves the operand of a load-type instruction in a 16-bit processor. It takes the current program counter, the instruction word and the value of the base register the instruction names. From them it forms an effective address in one of four ways. It then either returns that address as the result, or fetches one word or two chained words through a synchronous memory read port and returns the last word fetched.

Page-relative addresses are formed by splicing. The upper bits of the program counter are joined to a page offset taken from the instruction, so no adder sits in that path. The base-plus-index mode does use an adder. The address of every read is held in an address register before the memory sees it, and each returned word lands in a data register, which drives the result.

The surrounding pipeline raises `req_valid` for one cycle while `ready` is high. It then waits for the single-cycle `res_valid` pulse.

Top module: `paged_ea_unit`

## Requirements
- R1: While `rst_n` is low, `res_valid` and `mem_rd` are 0 and `ready` is 1. Reset takes effect without waiting for a clock edge, including in the middle of an access.
- R2: The mode is taken from `req_instr[15:14]`: 00 is page-immediate, 01 is direct, 10 is indirect and 11 is base-plus-index.
- R3: The page address is `{req_pc[15:9], req_instr[8:0]}`. The low nine bits of the program counter play no part, and nothing is added.
- R4: Page-immediate returns the page address on `res_data`, with `res_valid` high in the cycle after the accepting edge, and issues no memory read.
- R5: Direct issues one read at the page address and returns the word read. `res_valid` is high in the third cycle after the accepting edge.
- R6: Indirect reads at the page address, then reads again at the word returned, and returns the second word. The unit issues exactly two reads, and `res_valid` is high in the fifth cycle after the accepting edge.
- R7: Base-plus-index reads at `req_base + {10'b0, req_instr[5:0]}`, which wraps modulo 2^16. The unit issues one read and returns the word read, with `res_valid` high in the third cycle after the accepting edge.
- R8: Each read raises `mem_rd` for exactly one cycle, with the address on `mem_addr`. The unit takes `mem_rdata` in the following cycle.
- R9: `res_valid` is a one-cycle pulse, raised once per accepted request.
- R10: `ready` is low from the accepting edge through the cycle in which `res_valid` is high. A `req_valid` raised while `ready` is low is ignored and issues no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while ready is high |
| req_pc | input | 16 | Program counter of the instruction |
| req_instr | input | 16 | Instruction word (mode, page offset, index) |
| req_base | input | 16 | Base register value for base-plus-index |
| ready | output | 1 | Unit can accept a request this cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_rd |
| res_valid | output | 1 | Result pulse |
| res_data | output | 16 | Effective address or loaded word |

## Verification
The hardest situation to reach is a second request arriving while an indirect chase is still in flight. If that request were accepted, it would overwrite the address register between the two reads. The bench reaches it by starting an indirect access and holding `req_valid` high with a conflicting page-immediate instruction through every busy cycle. It then checks that the second read and the final word still follow the pointer chain. An asynchronous reset raised mid-chase is used as a second route into the same window.

// File: rtl/ea_pkg.sv
package ea_pkg;

  // Mode field values; the decode depends on this order.
  typedef enum logic [1:0] {
    EA_MODE_PAGE     = 2'b00,
    EA_MODE_DIRECT   = 2'b01,
    EA_MODE_INDIRECT = 2'b10,
    EA_MODE_BASED    = 2'b11
  } ea_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_ISSUE   = 2'b01,
    ST_CAPTURE = 2'b10
  } ea_state_e;

endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  // Assert asynchronously, release after STAGES clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/ea_addr_form.sv
module ea_addr_form
  import ea_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PAGE_W  = 9,
  parameter int INDEX_W = 6
) (
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] base_i,
  input  ea_mode_e          mode_i,
  output logic [DATA_W-1:0] ea_o
);

  localparam int HI_W   = DATA_W - PAGE_W;
  localparam int ZEXT_W = DATA_W - INDEX_W;
  localparam int MODE_LSB = DATA_W - 2;

  logic [DATA_W-1:0] page_addr;
  logic [DATA_W-1:0] based_addr;
  logic [DATA_W-1:0] index_ext;
  logic              unused_bits;

  // Page address is a splice: no carry path from offset into page bits.
  assign page_addr  = {pc_i[DATA_W-1 -: HI_W], instr_i[PAGE_W-1:0]};
  assign index_ext  = {{ZEXT_W{1'b0}}, instr_i[INDEX_W-1:0]};
  // Sum truncated to DATA_W bits: wraps modulo 2^DATA_W.
  assign based_addr = base_i + index_ext;

  assign ea_o = (mode_i == EA_MODE_BASED) ? based_addr : page_addr;

  assign unused_bits = ^{pc_i[PAGE_W-1:0], instr_i[DATA_W-1:MODE_LSB]};

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  ea_mode_e          req_mode_i,
  input  logic [DATA_W-1:0] ea_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              ready_o,
  output logic              mem_rd_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o
);

  ea_state_e         state_q, state_d;
  logic              chase_q, chase_d;
  logic [DATA_W-1:0] mar_q, mar_d;
  logic [DATA_W-1:0] mdr_q, mdr_d;
  logic              mar_en, mdr_en;
  logic              vld_q, vld_d;
  logic              accept;

  assign ready_o = (state_q == ST_IDLE) && !vld_q;
  assign accept  = req_valid_i && ready_o;

  // Next-state and datapath-enable logic.
  always_comb begin
    state_d = state_q;
    chase_d = chase_q;
    mar_d   = mar_q;
    mdr_d   = mdr_q;
    mar_en  = 1'b0;
    mdr_en  = 1'b0;
    vld_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_mode_i == EA_MODE_PAGE) begin
            mdr_d  = ea_i;
            mdr_en = 1'b1;
            vld_d  = 1'b1;
          end else begin
            mar_d   = ea_i;
            mar_en  = 1'b1;
            chase_d = (req_mode_i == EA_MODE_INDIRECT);
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        state_d = ST_CAPTURE;
      end
      ST_CAPTURE: begin
        mdr_d  = mem_rdata_i;
        mdr_en = 1'b1;
        if (chase_q) begin
          mar_d   = mem_rdata_i;
          mar_en  = 1'b1;
          chase_d = 1'b0;
          state_d = ST_ISSUE;
        end else begin
          vld_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      chase_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      chase_q <= chase_d;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q <= '0;
    end else if (mar_en) begin
      mar_q <= mar_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdr_q <= '0;
    end else if (mdr_en) begin
      mdr_q <= mdr_d;
    end
  end

  assign mem_rd_o    = (state_q == ST_ISSUE);
  assign mem_addr_o  = mar_q;
  assign res_valid_o = vld_q;
  assign res_data_o  = mdr_q;

  AST_PAGE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_mode_i == EA_MODE_PAGE) |=> (res_valid_o && !mem_rd_o)); // R4

  AST_FIRST_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_mode_i != EA_MODE_PAGE) |=> (mem_rd_o && mem_addr_o == $past(ea_i))); // R5

  AST_READ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o); // R8

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o); // R9

  AST_BUSY_DURING_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || res_valid_o) |-> !ready_o); // R10

endmodule

// File: rtl/paged_ea_unit.sv
module paged_ea_unit
  import ea_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PAGE_W     = 9,
  parameter int INDEX_W    = 6,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] req_pc,
  input  logic [DATA_W-1:0] req_instr,
  input  logic [DATA_W-1:0] req_base,
  output logic              ready,
  output logic              mem_rd,
  output logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);

  localparam int MODE_LSB = DATA_W - 2;

  logic              rst_sync_n;
  ea_mode_e          mode;
  logic [DATA_W-1:0] ea;

  assign mode = ea_mode_e'(req_instr[MODE_LSB +: 2]);

  ea_rst_sync #(
    .STAGES(RST_STAGES)
  ) i_rst_sync (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  ea_addr_form #(
    .DATA_W  (DATA_W),
    .PAGE_W  (PAGE_W),
    .INDEX_W (INDEX_W)
  ) i_addr_form (
    .pc_i    (req_pc),
    .instr_i (req_instr),
    .base_i  (req_base),
    .mode_i  (mode),
    .ea_o    (ea)
  );

  ea_ctrl #(
    .DATA_W(DATA_W)
  ) i_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_sync_n),
    .req_valid_i (req_valid),
    .req_mode_i  (mode),
    .ea_i        (ea),
    .mem_rdata_i (mem_rdata),
    .ready_o     (ready),
    .mem_rd_o    (mem_rd),
    .mem_addr_o  (mem_addr),
    .res_valid_o (res_valid),
    .res_data_o  (res_data)
  );

endmodule

// File: tb/test_paged_ea_unit.sv
module test_paged_ea_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MEM_SALT = 16'h1357;

  typedef struct packed {
    logic [15:0] pc;
    logic [15:0] instr;
    logic [15:0] base;
    logic [15:0] ea;
    logic [15:0] data;
    logic [1:0]  reads;
  } vec_t;

  // Memory model: word at address a is a + MEM_SALT (mod 2^16).
  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{16'h3A7F, 16'h0123, 16'h0000, 16'h3B23, 16'h3B23, 2'd0}, // page-immediate
    '{16'h81FF, 16'h0000, 16'h0000, 16'h8000, 16'h8000, 2'd0}, // low pc bits dropped
    '{16'h1234, 16'h40AB, 16'h0000, 16'h12AB, 16'h2602, 2'd1}, // direct
    '{16'hC1FF, 16'h41FF, 16'h0000, 16'hC1FF, 16'hD556, 2'd1}, // direct, max offset
    '{16'h5000, 16'h8010, 16'h0000, 16'h5010, 16'h76BE, 2'd2}, // indirect
    '{16'hEE00, 16'h81FE, 16'h0000, 16'hEFFE, 16'h16AC, 2'd2}, // indirect, pointer wraps
    '{16'hFFFF, 16'hC7EA, 16'h1000, 16'h102A, 16'h2381, 2'd1}, // based, mid bits ignored
    '{16'h0000, 16'hC03F, 16'hFFF0, 16'h002F, 16'h1386, 2'd1}, // based, sum wraps
    '{16'h0000, 16'hFFFF, 16'h0000, 16'h003F, 16'h1396, 2'd1}  // based, max index
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_pc, req_instr, req_base;
  logic        ready, mem_rd, res_valid;
  logic [15:0] mem_addr, mem_rdata, res_data;

  int          n_checks = 0;
  int          n_fail   = 0;
  int          rd_cnt   = 0;
  logic [15:0] rd_first;
  logic [15:0] rd_last;
  int          lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_ea_unit i_paged_ea_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_pc    (req_pc),
    .req_instr (req_instr),
    .req_base  (req_base),
    .ready     (ready),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  // Synchronous memory, one cycle of read latency, plus read bookkeeping.
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem_addr + MEM_SALT;
      if (rd_cnt == 0) rd_first = mem_addr;
      rd_last = mem_addr;
      rd_cnt  = rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Drive one request at a negedge; measure cycles until res_valid.
  task automatic run_req(input logic [15:0] pc, input logic [15:0] instr,
                         input logic [15:0] base);
    while (!ready) @(negedge clk);
    rd_cnt    = 0;
    req_valid = 1'b1;
    req_pc    = pc;
    req_instr = instr;
    req_base  = base;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!res_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "WATCHDOG", "timeout", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_pc    = '0;
    req_instr = '0;
    req_base  = '0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check(res_valid == 1'b0, "R1", "res_valid in reset", res_valid, 0);
    check(mem_rd == 1'b0, "R1", "mem_rd in reset", mem_rd, 0);
    check(ready == 1'b1, "R1", "ready in reset", ready, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table: R2 mode decode, R3 page splice, R4..R7 modes, R8 port, R9 pulse
    for (int i = 0; i < NVEC; i++) begin
      run_req(VECS[i].pc, VECS[i].instr, VECS[i].base);
      check(res_valid == 1'b1, "R2", "result seen", res_valid, 1);
      check(res_data == VECS[i].data, "R3_R4_R5_R6_R7", "result word", res_data, VECS[i].data);
      check(lat == 2 * VECS[i].reads + 1, "R4_R5_R6_R7", "latency", lat, 2 * VECS[i].reads + 1);
      check(rd_cnt == VECS[i].reads, "R8", "read count", rd_cnt, VECS[i].reads);
      if (VECS[i].reads != 0)
        check(rd_first == VECS[i].ea, "R3_R7", "first read address", rd_first, VECS[i].ea);
      if (VECS[i].reads == 2)
        check(rd_last == VECS[i].ea + MEM_SALT, "R6", "pointer read address",
              rd_last, VECS[i].ea + MEM_SALT);
      @(negedge clk);
      check(res_valid == 1'b0, "R9", "valid pulse ends", res_valid, 0);
    end

    // R10: requests held high during an indirect chase are ignored
    while (!ready) @(negedge clk);
    rd_cnt    = 0;
    req_valid = 1'b1;
    req_pc    = 16'h5000;
    req_instr = 16'h8010;
    @(negedge clk);
    req_pc    = 16'hFFFF;
    req_instr = 16'h0000;
    for (int k = 1; k <= 4; k++) begin
      check(ready == 1'b0, "R10", "ready low while busy", ready, 0);
      check(res_valid == 1'b0, "R10", "no early result", res_valid, 0);
      @(negedge clk);
    end
    check(res_valid == 1'b1, "R6", "chase result valid", res_valid, 1);
    check(ready == 1'b0, "R10", "ready low with result", ready, 0);
    check(res_data == 16'h76BE, "R10", "chase result unchanged", res_data, 16'h76BE);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(res_valid == 1'b0, "R10", "no result for ignored request", res_valid, 0);
    check(rd_cnt == 2, "R10", "no extra reads", rd_cnt, 2);

    // R1: asynchronous reset in the middle of an indirect chase
    rd_cnt    = 0;
    req_valid = 1'b1;
    req_pc    = 16'h5000;
    req_instr = 16'h8010;
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_rd == 1'b1, "R8", "read strobe after accept", mem_rd, 1);
    #1 rst_n = 1'b0;
    #1;
    check(mem_rd == 1'b0, "R1", "mem_rd cleared mid-access", mem_rd, 0);
    check(ready == 1'b1, "R1", "ready after async reset", ready, 1);
    check(res_valid == 1'b0, "R1", "res_valid after async reset", res_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(res_valid == 1'b0, "R1", "no stale result after reset", res_valid, 0);

    // R4: immediate right after reset recovery
    run_req(16'hABCD, 16'h0155, 16'h0000);
    check(res_data == 16'hAB55, "R4", "page-immediate after reset", res_data, 16'hAB55);
    check(rd_cnt == 0, "R4", "no read for immediate", rd_cnt, 0);

    finish_run();
  end

endmodule